// File: doc/BRIEF.md
# Miss-Driven Thread Criticality Predictor

This block sits beside the controller of a shared last-level cache and keeps a running score for every core. The score is the number of cache misses that the core has suffered recently. Each miss is weighted by the cache level that missed. A programmable interval timer clears all scores together, so that each score covers only recent behaviour. A core that has run out of work sends a steal request carrying its own index. The block then walks across the scores one core per clock, skips the requester, and reports the core with the highest score as the one to take work from. The highest score marks the thread that is falling furthest behind.

The scan is driven by a three-state machine. In `ST_IDLE` the block accepts a request (`ST_IDLE -> ST_SCAN` when `steal_req` is high). In `ST_SCAN` it examines one core per cycle (`ST_SCAN -> ST_SCAN` while cores remain, `ST_SCAN -> ST_REPORT` after the last core). In `ST_REPORT` it raises the victim strobe for one cycle (`ST_REPORT -> ST_IDLE` unconditionally). The raw scores are always visible on a flat output bus, so that software can read them.

Top module: `crit_predictor`

## Requirements
- R1: While reset is asserted and after it is released, every score reads zero, `steal_ready` is 1 and `victim_valid` is 0.
- R2: In each cycle a core's score rises by the sum of `W_L1` for each of its asserted first-level instruction and data miss strobes and `W_L2` for its asserted second-level miss strobe. Simultaneous strobes add together.
- R3: A score saturates at its all-ones value (2^CW - 1) instead of wrapping.
- R4: An interval timer is zero in the first cycle after reset. In any cycle where the timer is zero, all scores are cleared at the next edge and this overrides misses in the same cycle. The timer is then reloaded from `interval_bound`; otherwise it decrements. The clear period is therefore `interval_bound + 1` cycles, and a bound of 0 clears every cycle.
- R5: The reported victim is the core with the highest score, excluding the requester. Ties go to the lowest core index.
- R6: `victim_valid` is a single-cycle pulse. It appears exactly NCORE+1 cycles after the clock edge that accepted the request, with `victim_id` valid in that cycle.
- R7: `steal_ready` is low from the accepting edge until the victim pulse has ended. A request, or a changed requester index, presented while `steal_ready` is low is ignored.
- R8: Core i's score appears on `score_bus[i*CW +: CW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_l1i | input | NCORE | Per-core first-level instruction miss strobe |
| miss_l1d | input | NCORE | Per-core first-level data miss strobe |
| miss_l2 | input | NCORE | Per-core second-level miss strobe |
| interval_bound | input | BW | Reload value of the clear timer |
| steal_req | input | 1 | Steal request from an idle core |
| steal_id | input | IDW | Index of the requesting core |
| steal_ready | output | 1 | High when a request can be accepted |
| victim_valid | output | 1 | One-cycle strobe: victim index valid |
| victim_id | output | IDW | Index of the most critical core |
| score_bus | output | NCORE*CW | All scores, core 0 in the low bits |

## Verification
A wrong score, whether it comes from a bad weight, a wrap past the ceiling or a missed clear, shows on `score_bus` in the very next cycle. The bench keeps a cycle-accurate arithmetic model of every score and of the timer, and compares against it on every clock. A fault in the scan's comparison, its requester mask or its index counter only appears at the victim strobe, NCORE+1 cycles after the request. Each steal is therefore checked for both its latency and its chosen index, against an argmax computed from the model. Count patterns are set up so that ties, saturated cores and a requester that holds the maximum score all occur.

// File: rtl/crit_pkg.sv
package crit_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_REPORT = 2'd2
    } scan_state_t;
endpackage

// File: rtl/crit_counter.sv
// One saturating, weighted miss score for a single core.
module crit_counter #(
    parameter int CW   = 14,
    parameter int W_L1 = 1,
    parameter int W_L2 = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          ev_l1i,
    input  logic          ev_l1d,
    input  logic          ev_l2,
    output logic [CW-1:0] value
);
    localparam logic [31:0] CAP = 32'((64'd1 << CW) - 64'd1);

    logic [31:0] step;
    logic [31:0] total;
    logic [CW-1:0] nxt;

    always_comb begin
        step  = (ev_l1i ? 32'(W_L1) : 32'd0)
              + (ev_l1d ? 32'(W_L1) : 32'd0)
              + (ev_l2  ? 32'(W_L2) : 32'd0);
        total = 32'(value) + step;
        nxt   = (total > CAP) ? CAP[CW-1:0] : total[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     value <= '0;
        else if (clear) value <= '0;
        else            value <= nxt;
    end
endmodule

// File: rtl/crit_interval.sv
// Down-counting refresh timer; tick is high in the cycle it reads zero.
module crit_interval #(
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] bound,
    output logic          tick
);
    logic [BW-1:0] remain;

    assign tick = (remain == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    remain <= '0;
        else if (tick) remain <= bound;
        else           remain <= remain - 1'b1;
    end
endmodule

// File: rtl/crit_scan.sv
// Serial max-scan over all scores, one core per clock.
module crit_scan
    import crit_pkg::*;
#(
    parameter int NCORE = 8,
    parameter int CW    = 14,
    parameter int IDW   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCORE*CW-1:0] scores,
    input  logic                steal_req,
    input  logic [IDW-1:0]      steal_id,
    output logic                steal_ready,
    output logic                victim_valid,
    output logic [IDW-1:0]      victim_id,
    output logic [IDW-1:0]      req_q
);
    localparam logic [IDW-1:0] LAST = IDW'(NCORE - 1);

    scan_state_t   state, state_nxt;
    logic [IDW-1:0] idx;
    logic [CW-1:0]  best_val;
    logic [IDW-1:0] best_id;
    logic           have_best;
    logic [CW-1:0]  cur;
    logic           take;

    // Score of the core under examination.
    always_comb begin
        cur = '0;
        for (int i = 0; i < NCORE; i++) begin
            if (idx == IDW'(i)) cur = scores[i*CW +: CW];
        end
    end

    assign take = (idx != req_q) && (!have_best || (cur > best_val));

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next-state logic.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (steal_req) state_nxt = ST_SCAN;
            ST_SCAN:   if (idx == LAST) state_nxt = ST_REPORT;
            ST_REPORT: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // Scan datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            best_val  <= '0;
            best_id   <= '0;
            have_best <= 1'b0;
            req_q     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (steal_req) begin
                        req_q     <= steal_id;
                        idx       <= '0;
                        best_val  <= '0;
                        best_id   <= '0;
                        have_best <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    idx <= idx + 1'b1;
                    if (take) begin
                        best_val  <= cur;
                        best_id   <= idx;
                        have_best <= 1'b1;
                    end
                end
                ST_REPORT: ;
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        steal_ready  = (state == ST_IDLE);
        victim_valid = (state == ST_REPORT);
        victim_id    = best_id;
    end
endmodule

// File: rtl/crit_predictor.sv
// Top: per-core miss scores, refresh timer and steal-victim scan.
module crit_predictor #(
    parameter int NCORE = 8,
    parameter int CW    = 14,
    parameter int W_L1  = 1,
    parameter int W_L2  = 8,
    parameter int BW    = 16,
    parameter int IDW   = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCORE-1:0]    miss_l1i,
    input  logic [NCORE-1:0]    miss_l1d,
    input  logic [NCORE-1:0]    miss_l2,
    input  logic [BW-1:0]       interval_bound,
    input  logic                steal_req,
    input  logic [IDW-1:0]      steal_id,
    output logic                steal_ready,
    output logic                victim_valid,
    output logic [IDW-1:0]      victim_id,
    output logic [NCORE*CW-1:0] score_bus
);
    logic           refresh_tick;
    logic [IDW-1:0] scan_req;

    crit_interval #(.BW(BW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .bound (interval_bound),
        .tick  (refresh_tick)
    );

    for (genvar g = 0; g < NCORE; g++) begin : g_core
        crit_counter #(.CW(CW), .W_L1(W_L1), .W_L2(W_L2)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (refresh_tick),
            .ev_l1i (miss_l1i[g]),
            .ev_l1d (miss_l1d[g]),
            .ev_l2  (miss_l2[g]),
            .value  (score_bus[g*CW +: CW])
        );
    end

    crit_scan #(.NCORE(NCORE), .CW(CW), .IDW(IDW)) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .scores       (score_bus),
        .steal_req    (steal_req),
        .steal_id     (steal_id),
        .steal_ready  (steal_ready),
        .victim_valid (victim_valid),
        .victim_id    (victim_id),
        .req_q        (scan_req)
    );
endmodule

// File: rtl/crit_checker.sv
module crit_checker #(
    parameter int NCORE = 8,
    parameter int CW    = 14,
    parameter int IDW   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                refresh_tick,
    input logic [NCORE*CW-1:0] score_bus,
    input logic                steal_req,
    input logic                steal_ready,
    input logic                victim_valid,
    input logic [IDW-1:0]      victim_id,
    input logic [IDW-1:0]      scan_req
);
    for (genvar g = 0; g < NCORE; g++) begin : g_chk
        // R4: a timer tick empties every score by the next cycle
        a_r4_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            $past(refresh_tick) |-> (score_bus[g*CW +: CW] == '0));
        // R3: without a clear a score never goes down (no wrap)
        a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(refresh_tick) |-> (score_bus[g*CW +: CW] >= $past(score_bus[g*CW +: CW])));
    end

    // R6: victim strobe lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |=> !victim_valid);

    // R7: no new request accepted while a result is shown
    a_r7_busy_at_report: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> !steal_ready);

    // R7: an accepted request drops ready on the next cycle
    a_r7_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (steal_ready && steal_req) |=> !steal_ready);

    if (NCORE > 1) begin : g_self
        // R5: the requester is never named as the victim
        a_r5_not_self: assert property (@(posedge clk) disable iff (!rst_n)
            victim_valid |-> (victim_id != scan_req));
    end
endmodule

bind crit_predictor crit_checker #(.NCORE(NCORE), .CW(CW), .IDW(IDW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .refresh_tick (refresh_tick),
    .score_bus    (score_bus),
    .steal_req    (steal_req),
    .steal_ready  (steal_ready),
    .victim_valid (victim_valid),
    .victim_id    (victim_id),
    .scan_req     (scan_req)
);

// File: tb/sim_crit_predictor.sv
`timescale 1ns/1ps
module sim_crit_predictor;
    localparam int N   = 4;
    localparam int CW  = 6;
    localparam int W1  = 1;
    localparam int W2  = 8;
    localparam int BW  = 8;
    localparam int IDW = 2;
    localparam int CAP = (1 << CW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    miss_l1i = '0, miss_l1d = '0, miss_l2 = '0;
    logic [BW-1:0]   interval_bound = 8'd20;
    logic            steal_req = 1'b0;
    logic [IDW-1:0]  steal_id = '0;
    logic            steal_ready, victim_valid;
    logic [IDW-1:0]  victim_id;
    logic [N*CW-1:0] score_bus;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;
    string phase_tag = "R2";

    int m_cnt [N];
    int m_tm;

    always #10 clk = ~clk;

    crit_predictor #(.NCORE(N), .CW(CW), .W_L1(W1), .W_L2(W2), .BW(BW), .IDW(IDW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .miss_l1i(miss_l1i), .miss_l1d(miss_l1d), .miss_l2(miss_l2),
        .interval_bound(interval_bound),
        .steal_req(steal_req), .steal_id(steal_id),
        .steal_ready(steal_ready), .victim_valid(victim_valid),
        .victim_id(victim_id), .score_bus(score_bus)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Arithmetic model of scores and timer (R2, R3, R4).
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tm = 0;
            for (int i = 0; i < N; i++) m_cnt[i] = 0;
        end else if (m_tm == 0) begin
            for (int i = 0; i < N; i++) m_cnt[i] = 0;
            m_tm = int'(interval_bound);
        end else begin
            for (int i = 0; i < N; i++) begin
                m_cnt[i] += (miss_l1i[i] ? W1 : 0) + (miss_l1d[i] ? W1 : 0) + (miss_l2[i] ? W2 : 0);
                if (m_cnt[i] > CAP) m_cnt[i] = CAP;
            end
            m_tm--;
        end
    end

    // Per-cycle score comparison, core i at bits [i*CW +: CW] (R8).
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            for (int i = 0; i < N; i++)
                check(int'(score_bus[i*CW +: CW]) == m_cnt[i],
                      {phase_tag, "/R8 score"}, int'(score_bus[i*CW +: CW]), m_cnt[i]);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic int expect_victim(input int rid);
        int best = -1;
        for (int i = 0; i < N; i++)
            if (i != rid && (best < 0 || m_cnt[i] > m_cnt[best])) best = i;
        return best;
    endfunction

    task automatic do_steal(input int rid);
        int exp_v;
        int cyc;
        miss_l1i = '0; miss_l1d = '0; miss_l2 = '0;
        @(negedge clk);
        while (m_tm < N + 3) @(negedge clk);
        exp_v = expect_victim(rid);
        check(steal_ready == 1'b1, "R7 ready before request", int'(steal_ready), 1);
        steal_req = 1'b1;
        steal_id  = IDW'(rid);
        @(negedge clk);
        // R7: a changed requester index while busy must be ignored
        steal_id = IDW'(exp_v);
        cyc = 1;
        while (!victim_valid && cyc < N + 5) begin
            check(steal_ready == 1'b0, "R7 ready low while scanning", int'(steal_ready), 0);
            @(negedge clk);
            cyc++;
        end
        check(cyc == N + 1, "R6 victim latency", cyc, N + 1);
        check(int'(victim_id) == exp_v, "R5 victim index", int'(victim_id), exp_v);
        check(steal_ready == 1'b0, "R7 ready low at report", int'(steal_ready), 0);
        steal_req = 1'b0;
        @(negedge clk);
        check(victim_valid == 1'b0, "R6 single-cycle strobe", int'(victim_valid), 0);
        check(steal_ready == 1'b1, "R7 ready after report", int'(steal_ready), 1);
    endtask

    initial begin
        #(20.0 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while held in reset
        for (int i = 0; i < N; i++)
            check(score_bus[i*CW +: CW] == '0, "R1 score in reset", int'(score_bus[i*CW +: CW]), 0);
        check(steal_ready == 1'b1, "R1 ready in reset", int'(steal_ready), 1);
        check(victim_valid == 1'b0, "R1 strobe in reset", int'(victim_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(score_bus == '0, "R1 scores after release", int'(score_bus), 0);
        cmp_en = 1'b1;

        // Sweep all event combinations per core (R2, R3, R4).
        phase_tag = "R2/R3/R4";
        interval_bound = 8'd20;
        for (int c = 0; c < 600; c++) begin
            for (int i = 0; i < N; i++) begin
                int v = (c * (i + 1) + i) & 7;
                miss_l1i[i] = v[0]; miss_l1d[i] = v[1]; miss_l2[i] = v[2];
            end
            @(negedge clk);
        end

        // R4 boundary: bound of zero clears every cycle despite misses.
        phase_tag = "R4";
        interval_bound = 8'd0;
        miss_l1i = '1; miss_l1d = '1; miss_l2 = '1;
        repeat (40) @(negedge clk);
        check(score_bus == '0, "R4 bound zero keeps scores empty", int'(score_bus), 0);

        // Victim selection (R5, R6, R7).
        phase_tag = "R2/R3";
        interval_bound = 8'd200;
        miss_l1i = '0; miss_l1d = '0; miss_l2 = '0;
        repeat (3) @(negedge clk);
        for (int r = 0; r < N; r++) do_steal(r);          // all-equal tie
        for (int p = 0; p < 6; p++) begin
            for (int k = 0; k < 3; k++) begin
                for (int i = 0; i < N; i++) begin
                    int v = (p * 5 + i * 3 + k) & 7;
                    miss_l1i[i] = v[0]; miss_l1d[i] = v[1]; miss_l2[i] = (v[2] && (i != p % N));
                end
                @(negedge clk);
            end
            for (int r = 0; r < N; r++) do_steal(r);
        end
        // Drive everything to saturation: tie at the ceiling.
        miss_l2 = '1;
        repeat (12) @(negedge clk);
        for (int r = 0; r < N; r++) do_steal(r);

        cmp_en = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule